// File: doc/BRIEF.md
# UART FIFO Controller with Receive Threshold Interrupt

This block holds the two byte queues that sit between a UART's serial engines and the rest of the chip: one queue buffers received characters, the other buffers characters waiting to be sent. An 8-bit control byte, written through a single write strobe, switches both queues on or off, discards the contents of either queue on command, and selects how full the receive queue must become before an interrupt request is raised.

Each queue is 16 entries deep and presents its oldest byte at its pop data output before the pop. It reports full, empty and a 5-bit occupancy count. The serial shifters push into the receive queue and pop from the transmit queue. The host side does the reverse. A controller state machine with two states, `CTL_OFF` (queues disabled) and `CTL_ON` (queues enabled), tracks the enable bit. The `GO_ON` transition is taken on a write with bit 0 set while in `CTL_OFF`. The `GO_OFF` transition is taken on a write with bit 0 clear while in `CTL_ON`. Both transitions schedule a discard of both queues. Any other write holds the state (`STAY`). Discards land one clock after the write that requests them.

The interrupt is a level. It is high while the queues are enabled and the receive occupancy is at or above the selected threshold.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset, both queues are empty with count 0, the queues are disabled, the threshold select is 0, `cfg_value` reads 0x00 and `rx_irq` is low.
- R2: Bit 0 of the control byte enables both queues (1 = enabled). While they are disabled, pushes are dropped, both pop data outputs read 0x00 and `rx_irq` stays low.
- R3: A write whose bit 0 differs from the current enable value empties both queues and resets their pointers. This takes effect at the clock edge after the write, whether the enable bit rises or falls.
- R4: Bits 7:1 of a write are applied only when bit 0 of that same write is 1. Otherwise they are ignored and the stored threshold select is kept.
- R5: Writing 1 to bit 1 while enabling empties the receive queue one clock later and leaves the transmit queue untouched. Bit 1 always reads back as 0.
- R6: Writing 1 to bit 2 while enabling empties the transmit queue one clock later and leaves the receive queue untouched. Bit 2 always reads back as 0.
- R7: Bits 7:6 select the receive threshold: 0 selects 1 character, 1 selects 4, 2 selects 8 and 3 selects 14. `rx_irq` is high exactly when the queues are enabled and `rx_count` is greater than or equal to the selected threshold.
- R8: `rx_irq` falls in the same cycle that `rx_count` drops below the threshold, whether the drop comes from a pop or from a discard.
- R9: When a discard lands in the same cycle as a push or a pop on that queue, the discard wins and the queue ends empty.
- R10: Each queue returns bytes in the order they were pushed and holds up to 16. `full` is high at count 16 and `empty` is high at count 0. A push while full is dropped, and a pop while empty has no effect.
- R11: `cfg_value` reads back the enable in bit 0 and the threshold select in bits 7:6. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data |
| cfg_value | output | 8 | Control byte read-back |
| rx_push | input | 1 | Push a byte into the receive queue |
| rx_push_data | input | 8 | Byte to push into the receive queue |
| rx_pop | input | 1 | Pop the oldest receive byte |
| rx_pop_data | output | 8 | Oldest receive byte, or 0x00 when disabled or empty |
| rx_full | output | 1 | Receive queue holds 16 bytes |
| rx_empty | output | 1 | Receive queue holds no bytes |
| rx_count | output | 5 | Receive queue occupancy |
| tx_push | input | 1 | Push a byte into the transmit queue |
| tx_push_data | input | 8 | Byte to push into the transmit queue |
| tx_pop | input | 1 | Pop the oldest transmit byte |
| tx_pop_data | output | 8 | Oldest transmit byte, or 0x00 when disabled or empty |
| tx_full | output | 1 | Transmit queue holds 16 bytes |
| tx_empty | output | 1 | Transmit queue holds no bytes |
| tx_count | output | 5 | Transmit queue occupancy |
| rx_irq | output | 1 | Receive threshold interrupt, level |

## Verification
Every cycle, the assertions check the following:
- an enable change or a discard bit schedules the right discard;
- a write with bit 0 clear leaves the threshold untouched;
- a landed discard leaves the queue empty;
- the count never exceeds the depth;
- pushes into a full queue and pops from an empty one leave the count unchanged;
- the interrupt is never high while the queues are disabled or the receive queue is empty.

Only the directed scenarios can show the rest:
- the bytes come out in push order;
- each of the four threshold encodings fires at exactly its character count;
- a discard beats a push in the same cycle;
- the read-back hides the self-clearing bits.

// File: rtl/ufc_pkg.sv
package ufc_pkg;

    typedef enum logic [0:0] {
        CTL_OFF = 1'b0,
        CTL_ON  = 1'b1
    } ctl_state_t;

    // Threshold select to character count; the table is not linear.
    function automatic logic [4:0] thresh_chars(input logic [1:0] sel);
        logic [4:0] n;
        unique case (sel)
            2'd0: n = 5'd1;
            2'd1: n = 5'd4;
            2'd2: n = 5'd8;
            default: n = 5'd14;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [WIDTH-1:0]           push_data,
    input  logic                       pop,
    output logic [WIDTH-1:0]           head,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH):0]     count
);
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = AW + 1;
    localparam logic [AW-1:0]    LAST = AW'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             take, give;

    assign full  = (count == CAP);
    assign empty = (count == '0);
    assign take  = push && !full && !flush;
    assign give  = pop && !empty && !flush;
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (take) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (take) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (give) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            unique case ({take, give})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CAP);
    assert_full_push_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> $stable(count));
    assert_empty_pop_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !flush) |=> (count == '0));

endmodule

// File: rtl/ufc_ctrl.sv
module ufc_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output logic       en,
    output logic [1:0] trig_sel,
    output logic       flush_rx,
    output logic       flush_tx,
    output logic [7:0] cfg_value
);
    import ufc_pkg::*;

    localparam int BIT_EN   = 0;
    localparam int BIT_RXCL = 1;
    localparam int BIT_TXCL = 2;
    localparam int TRIG_LO  = 6;

    ctl_state_t state, state_nx;
    logic       toggle, upper_ok;

    assign en       = (state == CTL_ON);
    assign toggle   = we && (wdata[BIT_EN] != en);
    assign upper_ok = we && wdata[BIT_EN];

    // Transitions: GO_ON, GO_OFF, STAY
    always_comb begin
        state_nx = state;
        unique case (state)
            CTL_OFF: if (we && wdata[BIT_EN])  state_nx = CTL_ON;   // GO_ON
            CTL_ON:  if (we && !wdata[BIT_EN]) state_nx = CTL_OFF;  // GO_OFF
            default: state_nx = CTL_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CTL_OFF;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_sel <= 2'd0;
            flush_rx <= 1'b0;
            flush_tx <= 1'b0;
        end else begin
            flush_rx <= toggle || (upper_ok && wdata[BIT_RXCL]);
            flush_tx <= toggle || (upper_ok && wdata[BIT_TXCL]);
            if (upper_ok) trig_sel <= wdata[TRIG_LO +: 2];
        end
    end

    assign cfg_value = {trig_sel, 5'b00000, en};

    assert_toggle_flushes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (wdata[BIT_EN] != en)) |=> (flush_rx && flush_tx));
    assert_gated_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !wdata[BIT_EN]) |=> $stable(trig_sel));
    assert_rx_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata[BIT_EN] && wdata[BIT_RXCL]) |=> flush_rx);
    assert_tx_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata[BIT_EN] && wdata[BIT_TXCL]) |=> flush_tx);

endmodule

// File: rtl/ufc_rx_trigger.sv
module ufc_rx_trigger #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    output logic             irq
);
    import ufc_pkg::*;

    logic [CNT_W-1:0] level;

    assign level = CNT_W'(thresh_chars(trig_sel));
    assign irq   = en && (rx_count >= level);

    assert_irq_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> en);
    assert_irq_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rx_count != '0));

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl #(
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [7:0]             cfg_wdata,
    output logic [7:0]             cfg_value,
    input  logic                   rx_push,
    input  logic [7:0]             rx_push_data,
    input  logic                   rx_pop,
    output logic [7:0]             rx_pop_data,
    output logic                   rx_full,
    output logic                   rx_empty,
    output logic [$clog2(DEPTH):0] rx_count,
    input  logic                   tx_push,
    input  logic [7:0]             tx_push_data,
    input  logic                   tx_pop,
    output logic [7:0]             tx_pop_data,
    output logic                   tx_full,
    output logic                   tx_empty,
    output logic [$clog2(DEPTH):0] tx_count,
    output logic                   rx_irq
);
    localparam int CNT_W = $clog2(DEPTH) + 1;
    localparam int NQ    = 2;   // 0 = receive, 1 = transmit

    logic       en, flush_rx, flush_tx;
    logic [1:0] trig_sel;

    logic             q_flush [NQ];
    logic             q_push  [NQ];
    logic             q_pop   [NQ];
    logic [7:0]       q_wdata [NQ];
    logic [7:0]       q_head  [NQ];
    logic             q_full  [NQ];
    logic             q_empty [NQ];
    logic [CNT_W-1:0] q_count [NQ];

    ufc_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .wdata     (cfg_wdata),
        .en        (en),
        .trig_sel  (trig_sel),
        .flush_rx  (flush_rx),
        .flush_tx  (flush_tx),
        .cfg_value (cfg_value)
    );

    assign q_flush[0] = flush_rx;
    assign q_flush[1] = flush_tx;
    assign q_push[0]  = rx_push && en;
    assign q_push[1]  = tx_push && en;
    assign q_pop[0]   = rx_pop && en;
    assign q_pop[1]   = tx_pop && en;
    assign q_wdata[0] = rx_push_data;
    assign q_wdata[1] = tx_push_data;

    for (genvar g = 0; g < NQ; g++) begin : g_q
        byte_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (q_flush[g]),
            .push      (q_push[g]),
            .push_data (q_wdata[g]),
            .pop       (q_pop[g]),
            .head      (q_head[g]),
            .full      (q_full[g]),
            .empty     (q_empty[g]),
            .count     (q_count[g])
        );
    end

    assign rx_pop_data = (en && !q_empty[0]) ? q_head[0] : 8'h00;
    assign tx_pop_data = (en && !q_empty[1]) ? q_head[1] : 8'h00;
    assign rx_full     = q_full[0];
    assign tx_full     = q_full[1];
    assign rx_empty    = q_empty[0];
    assign tx_empty    = q_empty[1];
    assign rx_count    = q_count[0];
    assign tx_count    = q_count[1];

    ufc_rx_trigger #(.CNT_W(CNT_W)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .trig_sel (trig_sel),
        .rx_count (q_count[0]),
        .irq      (rx_irq)
    );

    assert_disabled_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (rx_pop_data == 8'h00 && tx_pop_data == 8'h00));
    assert_selfclear_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_value[5:1] == 5'b00000);

endmodule

// File: tb/tb_uart_fifo_ctrl.sv
module tb_uart_fifo_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_value;
    logic       rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
    logic [7:0] rx_push_data = 8'h00, tx_push_data = 8'h00;
    logic [7:0] rx_pop_data, tx_pop_data;
    logic       rx_full, rx_empty, tx_full, tx_empty, rx_irq;
    logic [4:0] rx_count, tx_count;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    uart_fifo_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_value(cfg_value),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop),
        .rx_pop_data(rx_pop_data), .rx_full(rx_full), .rx_empty(rx_empty),
        .rx_count(rx_count),
        .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop),
        .tx_pop_data(tx_pop_data), .tx_full(tx_full), .tx_empty(tx_empty),
        .tx_count(tx_count), .rx_irq(rx_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int level_of(input int sel);
        case (sel)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] d);
        rx_push = 1'b1; rx_push_data = d;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] d);
        tx_push = 1'b1; tx_push_data = d;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic pop_rx();
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic pop_tx();
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 cfg_value", cfg_value, 0);
        check("R1 rx_count", rx_count, 0);
        check("R1 tx_count", tx_count, 0);
        check("R1 rx_empty", rx_empty, 1);
        check("R1 tx_empty", tx_empty, 1);
        check("R1 rx_irq", rx_irq, 0);
    endtask

    task automatic t_disabled();
        push_rx(8'h55);
        push_tx(8'h66);
        check("R2 push dropped rx", rx_count, 0);
        check("R2 push dropped tx", tx_count, 0);
        check("R2 rx_pop_data zero", rx_pop_data, 0);
        check("R2 irq low", rx_irq, 0);
        wr(8'hC6);
        cyc();
        check("R4 upper bits ignored", cfg_value, 8'h00);
    endtask

    task automatic t_enable_same_write();
        wr(8'h41);
        check("R4 same-write enable applies", cfg_value, 8'h41);
        check("R11 readback", cfg_value, 8'h41);
        cyc();
    endtask

    task automatic t_order();
        for (int i = 0; i < 16; i++) push_tx(8'(i * 3 + 1));
        check("R10 full", tx_full, 1);
        check("R10 count16", tx_count, 16);
        push_tx(8'hEE);
        check("R10 push on full dropped", tx_count, 16);
        for (int i = 0; i < 16; i++) begin
            check("R10 order", tx_pop_data, (i * 3 + 1) & 8'hFF);
            pop_tx();
        end
        check("R10 empty", tx_empty, 1);
        pop_tx();
        check("R10 pop on empty", tx_count, 0);
    endtask

    task automatic t_trigger();
        for (int sel = 0; sel < 4; sel++) begin
            int lvl = level_of(sel);
            wr(8'(sel << 6) | 8'h03);   // enable, discard receive, select
            cyc();
            check("R5 rx cleared", rx_count, 0);
            for (int k = 1; k <= 15; k++) begin
                push_rx(8'(k));
                check("R7 irq vs threshold", rx_irq, (k >= lvl) ? 1 : 0);
            end
            for (int j = 14; j >= 0; j--) begin
                pop_rx();
                check("R8 irq after pop", rx_irq, (j >= lvl) ? 1 : 0);
            end
        end
    endtask

    task automatic t_single_flush();
        // threshold select is 3 here
        for (int i = 0; i < 3; i++) push_rx(8'h10 + 8'(i));
        for (int i = 0; i < 2; i++) push_tx(8'h20 + 8'(i));
        wr(8'hC3);
        check("R5 bit1 reads 0", cfg_value, 8'hC1);
        cyc();
        check("R5 rx emptied", rx_count, 0);
        check("R5 tx untouched", tx_count, 2);
        push_rx(8'hA1);
        wr(8'hC5);
        check("R6 bit2 reads 0", cfg_value, 8'hC1);
        cyc();
        check("R6 tx emptied", tx_count, 0);
        check("R6 rx untouched", rx_count, 1);
        check("R6 rx head kept", rx_pop_data, 8'hA1);
        // discard colliding with a push
        wr(8'hC3);
        push_rx(8'hB2);
        check("R9 flush beats push", rx_count, 0);
    endtask

    task automatic t_irq_flush();
        wr(8'h01);                      // select 1 char
        cyc();
        push_rx(8'h33);
        check("R7 irq at one", rx_irq, 1);
        wr(8'h03);
        check("R8 irq before flush lands", rx_irq, 1);
        cyc();
        check("R8 irq drops on flush", rx_irq, 0);
    endtask

    task automatic t_toggle();
        wr(8'hC1);
        cyc();
        for (int i = 0; i < 3; i++) begin
            push_rx(8'h40 + 8'(i));
            push_tx(8'h50 + 8'(i));
        end
        wr(8'h00);
        check("R4 trig kept on disable", cfg_value, 8'hC0);
        check("R2 irq low when disabled", rx_irq, 0);
        cyc();
        check("R3 falling clears rx", rx_count, 0);
        check("R3 falling clears tx", tx_count, 0);
        push_rx(8'h99);
        check("R2 push dropped disabled", rx_count, 0);
        check("R2 tx_pop_data zero", tx_pop_data, 0);
        wr(8'h01);
        check("R11 readback enable", cfg_value, 8'h01);
        push_rx(8'h77);
        check("R3 rising flush wins", rx_count, 0);
        push_rx(8'h78);
        check("R3 push after rise", rx_count, 1);
        check("R10 head after rise", rx_pop_data, 8'h78);
    endtask

    initial begin
        #(8 * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_disabled();
        t_enable_same_write();
        t_order();
        t_trigger();
        t_single_flush();
        t_irq_flush();
        t_toggle();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule